// File: doc/BRIEF.md
# Branch Target Generator with Displacement Prefix

This block produces the next program counter for every control-transfer instruction of a core with a 16-bit program address and 4-bit data registers. Each cycle it takes the current PC, a small operation code from the decoder, the 8-bit immediate field of the instruction, the A, BA and Y register values and the carry and zero flags. From these it drives the address of the next instruction, a taken indication, and for calls a push request with the return address. It handles relative jumps by a signed immediate, by the unsigned contents of A or BA, an absolute jump through Y, the four flag-conditional relative jumps, and relative calls.

A prefix instruction loads an 8-bit extension byte and arms a one-shot flag. While the flag is armed, the immediate-relative forms (plain, conditional and call) stop sign-extending their 8-bit field. They use the extension byte as the high half of a 16-bit displacement instead. The flag disarms when the next instruction completes, whether or not that instruction is a branch. The target datapath is purely combinational. Only the extension byte and its flag are registered.

Top module: `branch_target_gen`

## Requirements
- R1: After a synchronous active-high reset, `ext_active` is 0 and immediate-relative targets use the sign-extended 8-bit field.
- R2: For `op` = 1 (relative jump), `next_pc` = `pc` + sign-extended `imm8` + 1 and `taken` = 1, so the reach is -127 to +128 from the jump.
- R3: For `op` = 2 (carry set), 3 (carry clear), 4 (zero set) and 5 (zero clear), the jump is taken only when its condition on `flag_c`/`flag_z` holds, giving the R2 target. Otherwise `taken` = 0 and `next_pc` = `pc` + 1.
- R4: For `op` = 6, `next_pc` = `pc` + `reg_a` (unsigned, 0..15) + 1 with `taken` = 1.
- R5: For `op` = 7, `next_pc` = `pc` + `reg_ba` (unsigned, 0..255) + 1 with `taken` = 1.
- R6: For `op` = 8, `next_pc` = `reg_y` with `taken` = 1.
- R7: A completed instruction (`instr_valid` = 1) with `op` = 10 stores `imm8` as the extension byte and sets `ext_active` on the next cycle. Its own `next_pc` is `pc` + 1 with `taken` = 0.
- R8: While `ext_active` = 1, ops 1, 2-5 and 9 use the 16-bit displacement {extension byte, `imm8`} in place of the sign-extended field. Ops 6, 7 and 8 are unaffected (example: extension 0x15, `imm8` 0x7D, `pc` 0x1000 gives 0x257E).
- R9: A completed instruction with any `op` other than 10 clears `ext_active` on the next cycle. While `instr_valid` = 0, `ext_active` holds its value.
- R10: For `op` = 9 (relative call), the target follows R2/R8 with `taken` = 1 and `call_push` = 1. `ret_addr` always equals `pc` + 1, and `call_push` is 0 for every other op.
- R11: All PC arithmetic wraps modulo 2^16.
- R12: For `op` = 0 and codes 11 to 15 (non-branch), `next_pc` = `pc` + 1 and `taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The instruction presented this cycle completes at the coming edge |
| op | input | 4 | Control-transfer operation code from the decoder |
| pc | input | 16 | Address of the current instruction |
| imm8 | input | 8 | 8-bit immediate field of the instruction |
| reg_a | input | 4 | A register |
| reg_ba | input | 8 | BA register pair |
| reg_y | input | 16 | Y index register |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Control flow leaves the sequential path |
| call_push | output | 1 | Request to push `ret_addr` for a call |
| ret_addr | output | 16 | Return address, `pc` + 1 |
| ext_active | output | 1 | Extension byte is armed for the next instruction |

## Verification
`next_pc`, `taken`, `call_push` and `ret_addr` settle in the same cycle as their inputs, with no register in the path. The bench therefore drives at the falling edge and samples one time unit later, before the next rising edge. `ext_active` and the extension byte change only at a rising edge. Their effect is due in the cycle after the prefix: the bench updates its model flag just after each rising edge and checks that the following instruction's target uses it, including across cycles with `instr_valid` low. Expected targets come from plain 16-bit arithmetic on the bench's own copy of the prefix state.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int unsigned PC_W  = 16;
    localparam int unsigned NIB_W = 4;
    localparam int unsigned IMM_W = 8;
    localparam int unsigned OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_NONE  = 4'd0,
        OPC_JREL  = 4'd1,
        OPC_JCSET = 4'd2,
        OPC_JCCLR = 4'd3,
        OPC_JZSET = 4'd4,
        OPC_JZCLR = 4'd5,
        OPC_JNIB  = 4'd6,
        OPC_JPAIR = 4'd7,
        OPC_JABS  = 4'd8,
        OPC_CREL  = 4'd9,
        OPC_PFX   = 4'd10
    } bt_op_e;

    typedef struct packed {
        logic            redirect;
        logic            absolute;
        logic            is_call;
        logic [PC_W-1:0] disp;
    } bt_plan_t;

    function automatic logic cond_holds(input logic [OP_W-1:0] code,
                                        input logic c, input logic z);
        logic r;
        case (code)
            OPC_JCSET: r = c;
            OPC_JCCLR: r = ~c;
            OPC_JZSET: r = z;
            OPC_JZCLR: r = ~z;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic uses_imm_rel(input logic [OP_W-1:0] code);
        return (code == OPC_JREL) || (code == OPC_CREL) ||
               (code == OPC_JCSET) || (code == OPC_JCCLR) ||
               (code == OPC_JZSET) || (code == OPC_JZCLR);
    endfunction

endpackage

// File: rtl/bt_ext_prefix.sv
module bt_ext_prefix
    import bt_pkg::*;
#(
    parameter int unsigned P_PC_W  = PC_W,
    parameter int unsigned P_IMM_W = IMM_W,
    parameter bit          EXT_EN  = 1'b1,
    localparam int unsigned EXT_W  = P_PC_W - P_IMM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [OP_W-1:0]    op,
    input  logic [P_IMM_W-1:0] imm8,
    output logic               ext_on,
    output logic [EXT_W-1:0]   ext_byte
);

    generate
        if (EXT_EN) begin : g_ext
            logic             on_q;
            logic [EXT_W-1:0] byte_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    on_q   <= 1'b0;
                    byte_q <= '0;
                end else if (instr_valid) begin
                    if (op == OPC_PFX) begin
                        on_q   <= 1'b1;
                        byte_q <= EXT_W'(imm8);
                    end else begin
                        on_q   <= 1'b0;
                    end
                end
            end

            assign ext_on   = on_q;
            assign ext_byte = byte_q;
        end else begin : g_noext
            assign ext_on   = 1'b0;
            assign ext_byte = '0;
        end
    endgenerate

endmodule

// File: rtl/bt_disp_sel.sv
module bt_disp_sel
    import bt_pkg::*;
#(
    parameter int unsigned P_PC_W  = PC_W,
    parameter int unsigned P_NIB_W = NIB_W,
    parameter int unsigned P_IMM_W = IMM_W,
    localparam int unsigned EXT_W  = P_PC_W - P_IMM_W
) (
    input  logic [OP_W-1:0]    op,
    input  logic [P_IMM_W-1:0] imm8,
    input  logic [P_NIB_W-1:0] reg_a,
    input  logic [P_IMM_W-1:0] reg_ba,
    input  logic               flag_c,
    input  logic               flag_z,
    input  logic               ext_on,
    input  logic [EXT_W-1:0]   ext_byte,
    output bt_plan_t           plan
);

    logic [P_PC_W-1:0] rel_short;
    logic [P_PC_W-1:0] rel_long;
    logic [P_PC_W-1:0] rel_disp;

    assign rel_short = {{EXT_W{imm8[P_IMM_W-1]}}, imm8};
    assign rel_long  = {ext_byte, imm8};
    assign rel_disp  = ext_on ? rel_long : rel_short;

    always_comb begin
        plan          = '0;
        plan.disp     = rel_disp;
        case (op)
            OPC_JREL: begin
                plan.redirect = 1'b1;
            end
            OPC_CREL: begin
                plan.redirect = 1'b1;
                plan.is_call  = 1'b1;
            end
            OPC_JCSET, OPC_JCCLR, OPC_JZSET, OPC_JZCLR: begin
                plan.redirect = cond_holds(op, flag_c, flag_z);
            end
            OPC_JNIB: begin
                plan.redirect = 1'b1;
                plan.disp     = P_PC_W'(reg_a);
            end
            OPC_JPAIR: begin
                plan.redirect = 1'b1;
                plan.disp     = P_PC_W'(reg_ba);
            end
            OPC_JABS: begin
                plan.redirect = 1'b1;
                plan.absolute = 1'b1;
            end
            default: begin
                plan.redirect = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bt_target_add.sv
module bt_target_add
    import bt_pkg::*;
#(
    parameter int unsigned P_PC_W = PC_W
) (
    input  logic [P_PC_W-1:0] pc,
    input  logic [P_PC_W-1:0] reg_y,
    input  bt_plan_t          plan,
    output logic [P_PC_W-1:0] next_pc,
    output logic [P_PC_W-1:0] ret_addr,
    output logic              taken,
    output logic              call_push
);

    logic [P_PC_W-1:0] seq_pc;
    logic [P_PC_W-1:0] rel_pc;

    assign seq_pc = pc + P_PC_W'(1);
    assign rel_pc = seq_pc + plan.disp;

    always_comb begin
        if (!plan.redirect) begin
            next_pc = seq_pc;
        end else if (plan.absolute) begin
            next_pc = reg_y;
        end else begin
            next_pc = rel_pc;
        end
    end

    assign ret_addr  = seq_pc;
    assign taken     = plan.redirect;
    assign call_push = plan.is_call & plan.redirect;

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import bt_pkg::*;
#(
    parameter int unsigned P_PC_W  = PC_W,
    parameter int unsigned P_NIB_W = NIB_W,
    parameter int unsigned P_IMM_W = IMM_W,
    parameter bit          EXT_EN  = 1'b1,
    localparam int unsigned EXT_W  = P_PC_W - P_IMM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [OP_W-1:0]    op,
    input  logic [P_PC_W-1:0]  pc,
    input  logic [P_IMM_W-1:0] imm8,
    input  logic [P_NIB_W-1:0] reg_a,
    input  logic [P_IMM_W-1:0] reg_ba,
    input  logic [P_PC_W-1:0]  reg_y,
    input  logic               flag_c,
    input  logic               flag_z,
    output logic [P_PC_W-1:0]  next_pc,
    output logic               taken,
    output logic               call_push,
    output logic [P_PC_W-1:0]  ret_addr,
    output logic               ext_active
);

    logic             ext_on;
    logic [EXT_W-1:0] ext_byte;
    bt_plan_t         plan;

    bt_ext_prefix #(
        .P_PC_W  (P_PC_W),
        .P_IMM_W (P_IMM_W),
        .EXT_EN  (EXT_EN)
    ) u_prefix (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .op          (op),
        .imm8        (imm8),
        .ext_on      (ext_on),
        .ext_byte    (ext_byte)
    );

    bt_disp_sel #(
        .P_PC_W  (P_PC_W),
        .P_NIB_W (P_NIB_W),
        .P_IMM_W (P_IMM_W)
    ) u_sel (
        .op       (op),
        .imm8     (imm8),
        .reg_a    (reg_a),
        .reg_ba   (reg_ba),
        .flag_c   (flag_c),
        .flag_z   (flag_z),
        .ext_on   (ext_on),
        .ext_byte (ext_byte),
        .plan     (plan)
    );

    bt_target_add #(
        .P_PC_W (P_PC_W)
    ) u_add (
        .pc        (pc),
        .reg_y     (reg_y),
        .plan      (plan),
        .next_pc   (next_pc),
        .ret_addr  (ret_addr),
        .taken     (taken),
        .call_push (call_push)
    );

    assign ext_active = ext_on;

endmodule

// File: rtl/bt_checker.sv
module bt_checker
    import bt_pkg::*;
#(
    parameter int unsigned P_PC_W = PC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [OP_W-1:0]   op,
    input logic [P_PC_W-1:0] pc,
    input logic [P_PC_W-1:0] reg_y,
    input logic [P_PC_W-1:0] next_pc,
    input logic              taken,
    input logic              call_push,
    input logic [P_PC_W-1:0] ret_addr,
    input logic              ext_active
);

    assert_pfx_arms_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op == OPC_PFX) |=> ext_active);

    assert_pfx_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op != OPC_PFX) |=> !ext_active);

    assert_pfx_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(ext_active));

    assert_abs_target_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JABS) |-> (taken && next_pc == reg_y));

    assert_seq_fallthru_R12: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_pc == pc + P_PC_W'(1) && !call_push));

    assert_call_push_R10: assert property (@(posedge clk) disable iff (rst)
        call_push |-> (op == OPC_CREL && taken && ret_addr == pc + P_PC_W'(1)));

    assert_pfx_nobranch_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_PFX) |-> !taken);

endmodule

bind branch_target_gen bt_checker #(
    .P_PC_W (P_PC_W)
) u_bt_checker (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .op          (op),
    .pc          (pc),
    .reg_y       (reg_y),
    .next_pc     (next_pc),
    .taken       (taken),
    .call_push   (call_push),
    .ret_addr    (ret_addr),
    .ext_active  (ext_active)
);

// File: tb/branch_target_gen_bench.sv
module branch_target_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [3:0]  op;
    logic [15:0] pc;
    logic [7:0]  imm8;
    logic [3:0]  reg_a;
    logic [7:0]  reg_ba;
    logic [15:0] reg_y;
    logic        flag_c;
    logic        flag_z;
    logic [15:0] next_pc;
    logic        taken;
    logic        call_push;
    logic [15:0] ret_addr;
    logic        ext_active;

    int tests  = 0;
    int fails  = 0;
    bit m_on   = 1'b0;
    logic [7:0] m_ext = 8'h00;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_gen u_branch_target_gen (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .op          (op),
        .pc          (pc),
        .imm8        (imm8),
        .reg_a       (reg_a),
        .reg_ba      (reg_ba),
        .reg_y       (reg_y),
        .flag_c      (flag_c),
        .flag_z      (flag_z),
        .next_pc     (next_pc),
        .taken       (taken),
        .call_push   (call_push),
        .ret_addr    (ret_addr),
        .ext_active  (ext_active)
    );

    // Drive at a falling edge, check 1 unit later, commit at the rising edge.
    task automatic run(input string tag, input bit vld, input logic [3:0] o,
                       input logic [15:0] p, input logic [7:0] im,
                       input logic [3:0] a, input logic [7:0] ba,
                       input logic [15:0] y, input bit c, input bit z);
        logic [15:0] rel, e_next, e_ret;
        bit e_t, e_cp;
        instr_valid = vld; op = o; pc = p; imm8 = im;
        reg_a = a; reg_ba = ba; reg_y = y; flag_c = c; flag_z = z;
        rel    = m_on ? {m_ext, im} : {{8{im[7]}}, im};
        e_ret  = p + 16'd1;
        e_next = p + 16'd1;
        e_t    = 1'b0;
        e_cp   = 1'b0;
        case (o)
            4'd1: e_t = 1'b1;
            4'd9: begin e_t = 1'b1; e_cp = 1'b1; end
            4'd2: e_t = c;
            4'd3: e_t = !c;
            4'd4: e_t = z;
            4'd5: e_t = !z;
            4'd6: begin e_t = 1'b1; e_next = p + {12'd0, a} + 16'd1; end
            4'd7: begin e_t = 1'b1; e_next = p + {8'd0, ba} + 16'd1; end
            4'd8: begin e_t = 1'b1; e_next = y; end
            default: ;
        endcase
        if (e_t && (o == 4'd1 || o == 4'd9 || (o >= 4'd2 && o <= 4'd5)))
            e_next = p + rel + 16'd1;
        #1;
        tests++;
        if (next_pc !== e_next || taken !== e_t || call_push !== e_cp ||
            ret_addr !== e_ret || ext_active !== m_on) begin
            fails++;
            $display("FAIL %s op=%0d pc=%h: next=%h/%h taken=%b/%b push=%b/%b ret=%h/%h ext=%b/%b (actual/expected)",
                     tag, o, p, next_pc, e_next, taken, e_t, call_push, e_cp,
                     ret_addr, e_ret, ext_active, m_on);
        end
        @(posedge clk);
        if (vld) begin
            if (o == 4'd10) begin m_on = 1'b1; m_ext = im; end
            else m_on = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] pcs [4];
        pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'hFF80; pcs[3] = 16'hFFFF;
        rst = 1'b1; instr_valid = 1'b0; op = 4'd0; pc = 16'h0; imm8 = 8'h0;
        reg_a = 4'h0; reg_ba = 8'h0; reg_y = 16'h0; flag_c = 1'b0; flag_z = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, short displacement in use
        run("R1", 1'b0, 4'd1, 16'h0100, 8'h80, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);

        // R2 and R11: full immediate sweep at several PCs including wrap
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 256; i++)
                run("R2_R11", 1'b1, 4'd1, pcs[k], 8'(i), 4'h3, 8'h44, 16'h5555, 1'b0, 1'b0);

        // R3: every condition against every flag pair
        for (int o = 2; o <= 5; o++)
            for (int f = 0; f < 4; f++) begin
                run("R3", 1'b1, 4'(o), 16'h4000, 8'h05, 4'h0, 8'h0, 16'h0, f[0], f[1]);
                run("R3", 1'b1, 4'(o), 16'h0002, 8'hF0, 4'h0, 8'h0, 16'h0, f[0], f[1]);
            end

        // R4: every A value, with and without wrap
        for (int i = 0; i < 16; i++) begin
            run("R4", 1'b1, 4'd6, 16'h2000, 8'hFF, 4'(i), 8'h0, 16'h0, 1'b0, 1'b0);
            run("R4_R11", 1'b1, 4'd6, 16'hFFF8, 8'h80, 4'(i), 8'h0, 16'h0, 1'b0, 1'b0);
        end

        // R5: every BA value, unsigned even with the top bit set
        for (int i = 0; i < 256; i++)
            run("R5", 1'b1, 4'd7, 16'hFFA0, 8'h80, 4'h0, 8'(i), 16'h0, 1'b0, 1'b0);

        // R6: absolute targets
        for (int i = 0; i < 16; i++)
            run("R6", 1'b1, 4'd8, 16'h0F00, 8'h12, 4'h0, 8'h0, 16'(i * 16'h1111), 1'b1, 1'b1);

        // R12: non-branch codes
        for (int o = 0; o < 16; o++)
            if (o == 0 || o >= 11)
                run("R12", 1'b1, 4'(o), 16'hFFFF, 8'hAA, 4'h7, 8'h77, 16'h7777, 1'b1, 1'b0);

        // R10: calls, both displacement signs
        for (int i = 0; i < 256; i += 5)
            run("R10", 1'b1, 4'd9, 16'h8000, 8'(i), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);

        // R7 and R8: prefix then each immediate-relative form
        run("R7", 1'b1, 4'd10, 16'h0FFF, 8'h15, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R8", 1'b1, 4'd1, 16'h1000, 8'h7D, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        for (int e = 0; e < 256; e += 51)
            for (int i = 0; i < 256; i += 17) begin
                run("R7", 1'b1, 4'd10, 16'h3000, 8'(e), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
                run("R8", 1'b1, 4'd1, 16'hC001, 8'(i), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
                run("R7", 1'b1, 4'd10, 16'h3000, 8'(e), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
                run("R8_R10", 1'b1, 4'd9, 16'h7000, 8'(i), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
                run("R7", 1'b1, 4'd10, 16'h3000, 8'(e), 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
                run("R8_R3", 1'b1, 4'(2 + (i % 4)), 16'h0040, 8'(i), 4'h0, 8'h0, 16'h0, i[0], i[1]);
            end
        // R8: register and absolute forms ignore the prefix
        run("R7", 1'b1, 4'd10, 16'h0, 8'hEE, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R8", 1'b1, 4'd7, 16'h0100, 8'h00, 4'h0, 8'hC3, 16'h0, 1'b0, 1'b0);
        run("R7", 1'b1, 4'd10, 16'h0, 8'hEE, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R8", 1'b1, 4'd6, 16'h0100, 8'h00, 4'hB, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R7", 1'b1, 4'd10, 16'h0, 8'hEE, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R8", 1'b1, 4'd8, 16'h0100, 8'h00, 4'h0, 8'h0, 16'hBEEF, 1'b0, 1'b0);

        // R9: hold while idle, clear on an unrelated instruction
        run("R7", 1'b1, 4'd10, 16'h0, 8'h42, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R9", 1'b0, 4'd1, 16'h0200, 8'h10, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R9", 1'b0, 4'd0, 16'h0200, 8'h10, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R9", 1'b1, 4'd0, 16'h0200, 8'h10, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R9", 1'b1, 4'd1, 16'h0200, 8'hF0, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        // R7: back-to-back prefixes, the second byte wins
        run("R7", 1'b1, 4'd10, 16'h0, 8'h11, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R7", 1'b1, 4'd10, 16'h0, 8'h22, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        run("R7_R8", 1'b1, 4'd1, 16'h0000, 8'h00, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);

        // R1: reset clears an armed prefix
        run("R7", 1'b1, 4'd10, 16'h0, 8'h99, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_on = 1'b0;
        run("R1", 1'b1, 4'd1, 16'h0500, 8'h01, 4'h0, 8'h0, 16'h0, 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule